// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer (CAS-before-RAS)

This block owns refresh for an asynchronous DRAM whose internal row counter supplies the refresh address. After reset it waits out the power-up pause. It then runs a fixed number of CAS-before-RAS cycles, and only then reports the memory usable. From that point it owes one refresh for each elapsed refresh interval.

The block shares the RAS, CAS and WE strobes with a separate access controller. Whenever refreshes are owed it raises `ref_req`. It drives the strobes only while `ref_gnt` is high, and keeps `ref_req` high until the last strobe sequence has finished. Refreshes that come due while the grant is held back are stored, up to a limit, and served back to back once the grant arrives. WE stays high at all times, so the strobe pattern can never be taken as a test-mode entry.

The parameters are given in clock cycles. The defaults suit a 50 MHz clock: a 200 us pause, 8 initial cycles, a 15.6 us interval, 1 cycle of CAS lead, 3 cycles of RAS low and 2 cycles of precharge.

Top module: `dram_cbr_refresh_seq`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, `ras_n`, `cas_n` and `we_n` are 1 and `ref_req` and `mem_ready` are 0.
- R2: After reset is released, `ref_req` stays 0 and CAS stays high for exactly INIT_WAIT_CYC rising edges. `ref_req` is 1 after edge number INIT_WAIT_CYC.
- R3: `mem_ready` rises right after the INIT_REFRESHES-th refresh cycle completes, with exactly that many RAS falls before it. Once high it stays high until reset.
- R4: A strobe sequence starts (CAS falls) only if `ref_gnt` was 1 at the clock edge that started it. `ref_req` is 1 whenever RAS or CAS is low.
- R5: CAS falls while RAS is high and stays low for exactly CAS_LEAD_CYC cycles before RAS falls.
- R6: RAS stays low for exactly RAS_LOW_CYC cycles with CAS low throughout. RAS and CAS rise on the same edge.
- R7: After RAS rises, both strobes stay high for at least PRECH_CYC cycles before CAS falls again.
- R8: `we_n` is 1 at every RAS fall and at all other times.
- R9: After `mem_ready`, one refresh is owed every REFRESH_INTERVAL_CYC cycles. With the grant held high, consecutive RAS falls are exactly REFRESH_INTERVAL_CYC cycles apart.
- R10: While the grant is held low, the owed refreshes build up to at most MAX_OWED. When the grant returns, they are all served back to back, after which `ref_req` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Strobe ownership granted by the access controller |
| ref_req | output | 1 | Refresh owed or in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| mem_ready | output | 1 | Power-up initialization complete (sticky) |

## Verification
The bench checks the exact length of the power-up pause. A timer that is off by one would raise the request one cycle early or late. It counts RAS falls at the moment ready rises, which catches an initial cycle that is dropped or doubled. A monitor measures CAS lead, RAS low time and precharge on every pulse, and flags any pulse that starts without a grant, so an FSM that skips a phase or ignores the grant is caught. A table of grant-withholding lengths then checks that the owed count builds up and saturates: a counter that drops refreshes, or one that wraps past its limit, gives the wrong burst length.

// File: rtl/dram_cbr_refresh_seq.sv
module dram_cbr_refresh_seq #(
  parameter int unsigned INIT_WAIT_CYC        = 10000,
  parameter int unsigned INIT_REFRESHES       = 8,
  parameter int unsigned REFRESH_INTERVAL_CYC = 780,
  parameter int unsigned CAS_LEAD_CYC         = 1,
  parameter int unsigned RAS_LOW_CYC          = 3,
  parameter int unsigned PRECH_CYC            = 2,
  parameter int unsigned MAX_OWED             = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic mem_ready
);
  localparam int unsigned SEQ_MAX = (RAS_LOW_CYC > CAS_LEAD_CYC) ?
                                    ((RAS_LOW_CYC > PRECH_CYC) ? RAS_LOW_CYC : PRECH_CYC) :
                                    ((CAS_LEAD_CYC > PRECH_CYC) ? CAS_LEAD_CYC : PRECH_CYC);
  localparam int unsigned CNT_MAX = (INIT_WAIT_CYC > SEQ_MAX) ? INIT_WAIT_CYC : SEQ_MAX;
  localparam int unsigned CW = $clog2(CNT_MAX + 1);
  localparam int unsigned TW = $clog2(REFRESH_INTERVAL_CYC + 1);
  localparam int unsigned OW = $clog2(MAX_OWED + 1);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_LEAD, S_STROBE, S_PRECH} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic [OW-1:0] owed;
  logic [OW:0]   owed_sum;
  logic [OW-1:0] owed_nx;
  logic          rdy;

  wire tick = rdy && (tmr == TW'(REFRESH_INTERVAL_CYC - 1));
  wire done = (state == S_PRECH) && (cnt == CW'(PRECH_CYC - 1));
  wire busy = (state == S_LEAD) || (state == S_STROBE) || (state == S_PRECH);

  always_comb begin
    owed_sum = {1'b0, owed} + {{OW{1'b0}}, tick} - {{OW{1'b0}}, done};
    if (owed_sum > (OW+1)'(MAX_OWED)) owed_nx = OW'(MAX_OWED);
    else                              owed_nx = owed_sum[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_PWR;
      cnt   <= '0;
      tmr   <= '0;
      owed  <= '0;
      rdy   <= 1'b0;
    end else begin
      tmr  <= (!rdy || tick) ? '0 : tmr + 1'b1;
      owed <= owed_nx;
      unique case (state)
        S_PWR:
          if (cnt == CW'(INIT_WAIT_CYC - 1)) begin
            state <= S_IDLE;
            cnt   <= '0;
            owed  <= OW'(INIT_REFRESHES);
          end else cnt <= cnt + 1'b1;
        S_IDLE:
          if (owed != '0 && ref_gnt) begin
            state <= S_LEAD;
            cnt   <= '0;
          end
        S_LEAD:
          if (cnt == CW'(CAS_LEAD_CYC - 1)) begin
            state <= S_STROBE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        S_STROBE:
          if (cnt == CW'(RAS_LOW_CYC - 1)) begin
            state <= S_PRECH;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        S_PRECH:
          if (done) begin
            cnt <= '0;
            if (!rdy && owed == OW'(1)) rdy <= 1'b1;
            state <= (owed_nx != '0 && ref_gnt) ? S_LEAD : S_IDLE;
          end else cnt <= cnt + 1'b1;
        default: state <= S_PWR;
      endcase
    end
  end

  assign ref_req   = (owed != '0) || busy;
  assign cas_n     = !((state == S_LEAD) || (state == S_STROBE));
  assign ras_n     = (state != S_STROBE);
  assign we_n      = 1'b1;
  assign mem_ready = rdy;
endmodule

// File: rtl/dram_cbr_refresh_seq_chk.sv
module dram_cbr_refresh_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic ref_req,
  input logic ras_n,
  input logic cas_n,
  input logic mem_ready
);
  a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));
  a_r6_cas_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  a_r6_joint_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $rose(cas_n));
  a_r7_ras_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
  a_r4_start_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(ref_gnt));
  a_r4_req_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> ref_req);
  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_ready) |-> mem_ready);
endmodule

bind dram_cbr_refresh_seq dram_cbr_refresh_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ras_n(ras_n), .cas_n(cas_n), .mem_ready(mem_ready)
);

// File: tb/test_dram_cbr_refresh_seq.sv
module test_dram_cbr_refresh_seq;
  localparam int W = 20, NI = 3, IV = 60, LEAD = 1, LOW = 3, PRE = 2, MX = 4;
  localparam int NV = 5;
  // {cycles of interval withheld, expected burst length}
  localparam int VEC [NV][2] = '{'{1, 1}, '{2, 2}, '{3, 3}, '{6, 4}, '{4, 4}};

  logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b1;
  logic ref_req, ras_n, cas_n, we_n, mem_ready;
  int n_chk = 0, n_fail = 0, cyc = 0, wd = 0, pulses = 0;
  bit spacing_on = 1'b0;

  always #10 clk = ~clk;

  dram_cbr_refresh_seq #(.INIT_WAIT_CYC(W), .INIT_REFRESHES(NI), .REFRESH_INTERVAL_CYC(IV),
    .CAS_LEAD_CYC(LEAD), .RAS_LOW_CYC(LOW), .PRECH_CYC(PRE), .MAX_OWED(MX)) i_dram_cbr_refresh_seq (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .mem_ready(mem_ready));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
    wd <= wd + 1;
    if (wd > 100000) begin
      chk(1'b0, "watchdog", wd, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  logic p_ras = 1'b1, p_cas = 1'b1, p_gnt = 1'b0, p_rdy = 1'b0;
  bit req_seen = 1'b0, have_rise = 1'b0, have_fall = 1'b0;
  int lead_run = 0, low_run = 0, high_run = 0, last_fall = 0;

  always @(negedge clk) if (rst_n) begin
    if (!req_seen) begin
      if (ref_req) begin
        chk(cyc == W, "R2 first request cycle", cyc, W);
        req_seen = 1'b1;
      end else chk(cas_n && cyc < W, "R2 quiet during pause", cyc, W);
    end
    if (p_cas && !cas_n) begin
      chk(p_gnt, "R4 start without grant", p_gnt, 1);
      chk(ras_n, "R5 CAS falls while RAS high", ras_n, 1);
      if (have_rise) chk(high_run >= PRE, "R7 precharge", high_run, PRE);
    end
    if (p_ras && !ras_n) begin
      chk(lead_run == LEAD, "R5 CAS lead", lead_run, LEAD);
      chk(we_n == 1'b1, "R8 WE high", we_n, 1);
      pulses++;
      if (spacing_on && have_fall) chk(cyc - last_fall == IV, "R9 spacing", cyc - last_fall, IV);
      last_fall = cyc;
      have_fall = spacing_on;
    end
    if (!spacing_on) have_fall = 1'b0;
    if (!ras_n) chk(!cas_n, "R6 CAS low under RAS", cas_n, 0);
    if (!p_ras && ras_n) begin
      chk(low_run == LOW && cas_n, "R6 RAS low width / joint rise", low_run, LOW);
      have_rise = 1'b1;
      high_run = 0;
    end
    if (!ras_n || !cas_n) chk(ref_req, "R4 request held over strobe", ref_req, 1);
    if (mem_ready && !p_rdy) chk(pulses == NI, "R3 init count at ready", pulses, NI);
    if (p_rdy && !mem_ready) chk(1'b0, "R3 ready dropped", 0, 1);
    lead_run = (!cas_n && ras_n) ? lead_run + 1 : 0;
    low_run  = !ras_n ? low_run + 1 : 0;
    high_run = (ras_n && cas_n) ? high_run + 1 : 0;
    p_ras = ras_n; p_cas = cas_n; p_gnt = ref_gnt; p_rdy = mem_ready;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!ref_req && !mem_ready, "R1 req/ready low in reset", {ref_req, mem_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && !ref_req && !mem_ready, "R1 state after release",
        {ras_n, cas_n, we_n, ref_req, mem_ready}, 5'b11100);
    while (!mem_ready) @(negedge clk);
    chk(pulses == NI, "R3 init pulses", pulses, NI);
    spacing_on = 1'b1;
    repeat (4 * IV + 10) @(negedge clk);
    chk(pulses == NI + 4, "R9 periodic count", pulses, NI + 4);
    spacing_on = 1'b0;
    for (int v = 0; v < NV; v++) begin
      int base;
      while (ref_req) @(negedge clk);
      ref_gnt = 1'b0;
      while (!ref_req) @(negedge clk);
      repeat ((VEC[v][0] - 1) * IV + IV / 2) @(negedge clk);
      chk(cas_n && ref_req, "R4 no strobe while grant low", cas_n, 1);
      base = pulses;
      ref_gnt = 1'b1;
      @(negedge clk);
      while (ref_req) @(negedge clk);
      chk(pulses - base == VEC[v][1], "R10 owed burst", pulses - base, VEC[v][1]);
    end
    chk(mem_ready && we_n, "R3/R8 final", {mem_ready, we_n}, 3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule